// File: doc/BRIEF.md
# Handshaked Register FIFO Channel

This block is a point-to-point message channel made of flip-flops. It links one hardware producer to one hardware consumer inside the same clock domain and delivers messages strictly in arrival order. The producer pushes a message by holding it on the write bus and raising the write strobe for one cycle while the channel reports ready. It reads two status pins: ready, which means there is room for another message, and sync, which means every message has been consumed. The producer can use sync to wait until the consumer has drained the channel.

The consumer side is a valid/pop pair. The oldest message sits on the head bus whenever valid is high, so the consumer can inspect it (peek) for as many cycles as it likes. The message leaves only when the consumer raises pop while valid is high. Either side can raise its own clear pin to throw away every stored message at once. A clear has priority over a write or a pop in the same cycle.

Back-pressure rules. A write counts only in a cycle where ready is high at the clock edge. The producer must hold its message and retry until ready returns. A pop counts only when valid is high. A write and a pop may complete in the same cycle, but only while the channel is neither empty nor full.

Top module: `msg_fifo_chan`

## Requirements
- R1: `prod_rdy` is low while reset is held, in the first cycle after reset is released, and whenever `DEPTH` messages are stored; otherwise it is high.
- R2: A write is accepted at a clock edge only when `prod_wr` and `prod_rdy` are both high. A write attempted while `prod_rdy` is low leaves the stored contents unchanged.
- R3: Messages reach the consumer in exactly the order they were accepted, with no loss and no duplication.
- R4: `cons_valid` is high exactly when at least one message is stored. `cons_data` shows the oldest stored message and keeps that value for as long as no pop or clear occurs (peek).
- R5: A pop removes exactly one message at a clock edge where `cons_pop` and `cons_valid` are both high. A pop while the channel is empty has no effect, even in a cycle where a write fills the channel.
- R6: `prod_sync` is high exactly when no message is stored, and it is high during reset.
- R7: Raising `prod_clr` or `cons_clr` for one cycle empties the channel at that clock edge. In the next cycle `prod_sync` is high and `cons_valid` is low.
- R8: When a clear coincides with a write or a pop, the clear wins. The write is dropped, and no old message reappears afterwards.
- R9: In the cycle after a clear, `prod_rdy` is low. It returns high in the following cycle unless another clear is raised.
- R10: A write and a pop that both complete in the same cycle leave the number of stored messages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_data | input | DATA_W | Message offered by the producer |
| prod_wr | input | 1 | Write strobe, one cycle per message |
| prod_clr | input | 1 | Producer-side clear of all stored messages |
| prod_rdy | output | 1 | Room available for a write |
| prod_sync | output | 1 | Channel holds no messages |
| cons_valid | output | 1 | A message is at the head |
| cons_data | output | DATA_W | Oldest stored message (peek) |
| cons_pop | input | 1 | Remove the head message |
| cons_clr | input | 1 | Consumer-side clear of all stored messages |

## Verification
If the occupancy count is wrong, the error shows at once in `prod_rdy`, `prod_sync` and `cons_valid`, which the reference queue predicts every cycle. If a pointer is wrong, the error shows as a wrong value on `cons_data` at the next pop, or while a peek is held. A clear that does not fully reset the pointers is exposed by the write made right after it: the head must then be that new message and not an older one. Filling the channel and writing once more checks that an ignored write leaves no trace; the bench drains the channel and confirms that valid drops after exactly `DEPTH` pops.

// File: rtl/msg_fifo_pkg.sv
package msg_fifo_pkg;

  // Per-cycle actions that the storage and pointer logic carry out.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifo_op_t;

endpackage

// File: rtl/mfc_op_decode.sv
module mfc_op_decode
  import msg_fifo_pkg::*;
(
  input  logic     wr_req,
  input  logic     rdy,
  input  logic     pop_req,
  input  logic     valid,
  input  logic     prod_clr,
  input  logic     cons_clr,
  output fifo_op_t op
);

  always_comb begin
    op.flush = prod_clr | cons_clr;
    op.push  = wr_req  & rdy   & ~op.flush;
    op.pop   = pop_req & valid & ~op.flush;
  end

endmodule

// File: rtl/mfc_ptr_ctrl.sv
module mfc_ptr_ctrl
  import msg_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fifo_op_t      op,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);

  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || op.flush) begin
      wr_idx <= '0;
      rd_idx <= '0;
      occ    <= '0;
    end else begin
      if (op.push) wr_idx <= step_idx(wr_idx);
      if (op.pop)  rd_idx <= step_idx(rd_idx);
      case ({op.push, op.pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);

endmodule

// File: rtl/mfc_reg_store.sv
module mfc_reg_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (we && (wr_idx == AW'(g)))
        slot[g] <= wdata;
    end
  end

  assign rdata = slot[rd_idx];

endmodule

// File: rtl/mfc_status.sv
module mfc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic full,
  input  logic empty,
  output logic rdy,
  output logic sync,
  output logic valid
);

  // Blocks writes for one cycle after reset release and after every clear.
  logic hold;

  always_ff @(posedge clk) begin
    if (!rst_n) hold <= 1'b1;
    else        hold <= flush;
  end

  assign rdy   = rst_n & ~full & ~hold;
  assign sync  = empty;
  assign valid = ~empty;

endmodule

// File: rtl/msg_fifo_chan.sv
module msg_fifo_chan
  import msg_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] prod_data,
  input  logic              prod_wr,
  input  logic              prod_clr,
  output logic              prod_rdy,
  output logic              prod_sync,
  output logic              cons_valid,
  output logic [DATA_W-1:0] cons_data,
  input  logic              cons_pop,
  input  logic              cons_clr
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fifo_op_t      op;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] occ_cnt;
  logic          full, empty;

  mfc_op_decode u_dec (
    .wr_req   (prod_wr),
    .rdy      (prod_rdy),
    .pop_req  (cons_pop),
    .valid    (cons_valid),
    .prod_clr (prod_clr),
    .cons_clr (cons_clr),
    .op       (op)
  );

  mfc_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .occ    (occ_cnt),
    .full   (full),
    .empty  (empty)
  );

  mfc_reg_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (op.push),
    .wr_idx (wr_idx),
    .wdata  (prod_data),
    .rd_idx (rd_idx),
    .rdata  (cons_data)
  );

  mfc_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (op.flush),
    .full  (full),
    .empty (empty),
    .rdy   (prod_rdy),
    .sync  (prod_sync),
    .valid (cons_valid)
  );

endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prod_wr,
  input logic              prod_rdy,
  input logic              prod_clr,
  input logic              prod_sync,
  input logic              cons_valid,
  input logic [DATA_W-1:0] cons_data,
  input logic              cons_pop,
  input logic              cons_clr,
  input logic [CW-1:0]     cnt
);

  logic flush;
  assign flush = prod_clr | cons_clr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !prod_rdy); // R1

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_wr && prod_rdy && !flush && !(cons_pop && cons_valid)) |=> (cnt == $past(cnt) + 1'b1)); // R2

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && !cons_pop && !flush) |=> (cons_valid && $stable(cons_data))); // R4

  AST_CLR_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (prod_sync && !cons_valid)); // R7

  AST_CLR_BLOCKS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !prod_rdy); // R9

  AST_PAIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_wr && prod_rdy && cons_pop && cons_valid && !flush) |=> $stable(cnt)); // R10

endmodule

bind msg_fifo_chan mfc_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mfc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prod_wr    (prod_wr),
  .prod_rdy   (prod_rdy),
  .prod_clr   (prod_clr),
  .prod_sync  (prod_sync),
  .cons_valid (cons_valid),
  .cons_data  (cons_data),
  .cons_pop   (cons_pop),
  .cons_clr   (cons_clr),
  .cnt        (occ_cnt)
);

// File: tb/msg_fifo_chan_bench.sv
module msg_fifo_chan_bench;

  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int DEP   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] prod_data = '0;
  logic          prod_wr = 1'b0, prod_clr = 1'b0, cons_pop = 1'b0, cons_clr = 1'b0;
  logic          prod_rdy, prod_sync, cons_valid;
  logic [DW-1:0] cons_data;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] exp_q [$];
  bit hold_m = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  msg_fifo_chan #(.DATA_W(DW), .DEPTH(DEP)) u_msg_fifo_chan (
    .clk(clk), .rst_n(rst_n), .prod_data(prod_data), .prod_wr(prod_wr),
    .prod_clr(prod_clr), .prod_rdy(prod_rdy), .prod_sync(prod_sync),
    .cons_valid(cons_valid), .cons_data(cons_data), .cons_pop(cons_pop),
    .cons_clr(cons_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Advance one clock edge; returns just after the following falling edge.
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Monitor: one time unit before each rising edge, compare the ports against
  // the reference queue, then apply the handshakes that this edge completes.
  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (rst_n) begin
      bit clr_now, exp_rdy;
      clr_now = prod_clr | cons_clr;
      exp_rdy = !hold_m && (exp_q.size() < DEP);
      chk(prod_rdy == exp_rdy, "R1 ready", 32'(prod_rdy), 32'(exp_rdy));
      chk(prod_sync == (exp_q.size() == 0), "R6 sync", 32'(prod_sync), 32'(exp_q.size() == 0));
      chk(cons_valid == (exp_q.size() != 0), "R4 valid", 32'(cons_valid), 32'(exp_q.size() != 0));
      if (cons_valid && exp_q.size() != 0)
        chk(cons_data == exp_q[0], "R3 order", 32'(cons_data), 32'(exp_q[0]));
      if (clr_now) begin
        exp_q.delete();
        hold_m = 1'b1;
      end else begin
        if (cons_pop && exp_q.size() != 0) void'(exp_q.pop_front());
        if (prod_wr && exp_rdy) exp_q.push_back(prod_data);
        hold_m = 1'b0;
      end
    end else begin
      hold_m = 1'b1;
    end
  end

  task automatic put(input logic [DW-1:0] d);
    prod_data = d;
    prod_wr = 1'b1;
    step();
    prod_wr = 1'b0;
  endtask

  task automatic pop_n(input int n);
    cons_pop = 1'b1;
    for (int i = 0; i < n; i++) step();
    cons_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // Reset state (R1, R6)
    step(); step(); step();
    chk(prod_rdy == 1'b0, "R1 reset", 32'(prod_rdy), 0);
    chk(prod_sync == 1'b1, "R6 reset", 32'(prod_sync), 1);
    chk(cons_valid == 1'b0, "R4 reset", 32'(cons_valid), 0);
    rst_n = 1'b1;
    chk(prod_rdy == 1'b0, "R1 first cycle", 32'(prod_rdy), 0);
    step();
    chk(prod_rdy == 1'b1, "R1 after release", 32'(prod_rdy), 1);

    // Fill, then write once more while full: ignored (R1, R2)
    for (int i = 0; i < DEP; i++) put(DW'(16'h0100 + i));
    chk(prod_rdy == 1'b0, "R1 full", 32'(prod_rdy), 0);
    put(16'h0BAD);
    pop_n(DEP);
    chk(cons_valid == 1'b0, "R2 write while full ignored", 32'(cons_valid), 0);

    // Peek: head holds while no pop (R4)
    put(16'h00A1);
    put(16'h00A2);
    for (int i = 0; i < 3; i++) begin
      chk(cons_data == 16'h00A1, "R4 peek", 32'(cons_data), 32'h00A1);
      step();
    end
    pop_n(2);

    // Pop while empty, including a cycle with a write (R5)
    cons_pop = 1'b1;
    step();
    chk(cons_valid == 1'b0, "R5 pop on empty", 32'(cons_valid), 0);
    prod_data = 16'h0055;
    prod_wr = 1'b1;
    step();
    prod_wr = 1'b0;
    cons_pop = 1'b0;
    chk(cons_valid == 1'b1, "R5 item kept", 32'(cons_valid), 1);
    chk(cons_data == 16'h0055, "R5 item data", 32'(cons_data), 32'h0055);
    pop_n(1);

    // Producer clear with write in the same cycle (R7, R8, R9)
    put(16'h00C1);
    put(16'h00C2);
    prod_clr = 1'b1;
    prod_wr = 1'b1;
    prod_data = 16'h00C3;
    step();
    prod_clr = 1'b0;
    prod_wr = 1'b0;
    chk(cons_valid == 1'b0, "R7 producer clear", 32'(cons_valid), 0);
    chk(prod_sync == 1'b1, "R7 sync after clear", 32'(prod_sync), 1);
    chk(prod_rdy == 1'b0, "R9 ready blocked", 32'(prod_rdy), 0);
    step();
    chk(prod_rdy == 1'b1, "R9 ready back", 32'(prod_rdy), 1);
    chk(cons_valid == 1'b0, "R8 write dropped", 32'(cons_valid), 0);

    // Consumer clear with pop in the same cycle (R7, R8)
    put(16'h00D1);
    put(16'h00D2);
    put(16'h00D3);
    cons_clr = 1'b1;
    cons_pop = 1'b1;
    step();
    cons_clr = 1'b0;
    cons_pop = 1'b0;
    chk(cons_valid == 1'b0, "R7 consumer clear", 32'(cons_valid), 0);
    step();
    put(16'h00E9);
    chk(cons_data == 16'h00E9, "R8 no stale head", 32'(cons_data), 32'h00E9);
    pop_n(1);

    // Streaming: write and pop together keep occupancy (R10)
    put(16'h00F0);
    prod_wr = 1'b1;
    cons_pop = 1'b1;
    for (int i = 0; i < 6; i++) begin
      prod_data = DW'(16'h00F1 + i);
      step();
      chk(cons_valid == 1'b1, "R10 steady valid", 32'(cons_valid), 1);
    end
    prod_wr = 1'b0;
    step();
    cons_pop = 1'b0;
    chk(cons_valid == 1'b0, "R10 one item left", 32'(cons_valid), 0);

    step();
    finish_run();
  end

endmodule